// File: doc/BRIEF.md
# ADC Auto-Trigger Start Generator

This block decides when an analog-to-digital converter begins a conversion without software asking for it. A three-bit code in a small configuration register picks one of several interrupt-flag inputs: comparator, external interrupt, two timer compare matches, timer overflow and pin change. The block watches the picked flag through a multiplexer and issues a one-cycle start pulse when the multiplexer output rises. Because the edge is taken after the multiplexer, rewriting the code so that it points from a low flag to a high flag is itself a rising edge and starts a conversion. Code zero means free-running operation. In that mode the multiplexer output is held low, so entering the mode never fires, and each conversion-complete strobe instead requests the next conversion.

A second register masks the digital readback of the six shared analog pins. It covers four converter pins and two comparator inputs, and each set bit forces the matching readback to zero. Both registers sit behind a one-bit-address write/read port. The start pulse is qualified by the auto-trigger enable, the converter enable and the busy input.

Top module: `adc_trig_sel`

## Requirements
- R1: The trigger register is at address 0 with the code in bits 2:0. Codes 1 to 6 select trig_flags bit (code-1): 1 comparator, 2 external interrupt 0, 3 timer compare A, 4 timer overflow, 5 timer compare B, 6 pin change.
- R2: A start is requested by a 0-to-1 change of the selected flag between two consecutive clock edges, not by its level. start_conv is high for exactly the one cycle after the edge where the rise is seen, and a flag held high gives a single start.
- R3: While auto_en is low, start_conv stays low whatever the code and flags. The stored previous multiplexer value keeps updating, so a flag that is already high when auto_en rises does not trigger.
- R4: A register write that moves the code from a source whose flag is low to one whose flag is high produces a start on the cycle after the clock edge that follows the write.
- R5: A write of code 0 never produces a start by itself, even when every flag is high.
- R6: With code 0, auto_en and conv_en high and conv_busy low, a conv_done strobe gives start_conv high on the following cycle.
- R7: While conv_en is low, no start is produced.
- R8: A request in a cycle where conv_busy is high is dropped and is not retried later.
- R9: Code 7 is a source tied to zero and never produces a start.
- R10: Reads of address 0 return bits 7:3 as zero. Writes to those bits are ignored, and both registers reset to zero.
- R11: The pin-disable register is at address 1, with bits 5:2 for the converter pins and bits 1:0 for the comparator inputs. Bits 7:6 read as zero. pin_rd[i] equals pin_raw[i] when bit i is clear and is zero when bit i is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 trigger code, 1 pin disable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| trig_flags | input | 6 | Interrupt flags for trigger codes 1 to 6 |
| auto_en | input | 1 | Auto-trigger enable |
| conv_en | input | 1 | Converter enable |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | Conversion-complete strobe |
| pin_raw | input | 6 | Raw digital pin values |
| pin_rd | output | 6 | Masked pin readback |
| start_conv | output | 1 | One-cycle start-conversion pulse |

## Verification
The only hidden state is the stored previous multiplexer value, together with the two registers. A wrong stored value shows up at start_conv one cycle later, either as a missing start on a real rise or as a spurious start when the code changes or auto_en returns. A bad register bit shows up at once on reg_rdata or pin_rd, and on start_conv within two cycles of the next flag rise. The bench compares every output against a behavioural model on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;

    typedef enum logic {
        REG_TRIG = 1'b0,
        REG_PDIS = 1'b1
    } reg_addr_e;

    typedef enum logic [2:0] {
        TRG_FREE = 3'd0,
        TRG_ACMP = 3'd1,
        TRG_EXT0 = 3'd2,
        TRG_CMPA = 3'd3,
        TRG_OVF  = 3'd4,
        TRG_CMPB = 3'd5,
        TRG_PCHG = 3'd6,
        TRG_NONE = 3'd7
    } trig_src_e;

endpackage

// File: rtl/adc_trig_regs.sv
`timescale 1ns/1ps
module adc_trig_regs
    import adc_trig_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int PIN_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SEL_W-1:0]  sel,
    output logic [PIN_W-1:0]  dis
);
    localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'((1 << SEL_W) - 1);
    localparam logic [DATA_W-1:0] PDIS_MASK = DATA_W'((1 << PIN_W) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] trig;
        logic [DATA_W-1:0] pdis;
    } regs_t;

    regs_t r_d, r_q;

    // next-state: only implemented bits are stored, the rest stay zero
    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                REG_TRIG: r_d.trig = wdata & TRIG_MASK;
                REG_PDIS: r_d.pdis = wdata & PDIS_MASK;
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr_e'(addr))
            REG_TRIG: rdata = r_q.trig;
            REG_PDIS: rdata = r_q.pdis;
            default:  rdata = '0;
        endcase
    end

    assign sel = r_q.trig[SEL_W-1:0];
    assign dis = r_q.pdis[PIN_W-1:0];
endmodule

// File: rtl/adc_trig_srcmux.sv
`timescale 1ns/1ps
module adc_trig_srcmux #(
    parameter int SEL_W = 3,
    localparam int NUM_SRC   = 1 << SEL_W,
    localparam int NUM_FLAGS = NUM_SRC - 2
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic                 mux_out
);
    logic [NUM_SRC-1:0] src_vec;

    // slot 0 is free-running (held low), last slot is tied low
    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
            if (k == 0 || k > NUM_FLAGS) begin : g_zero
                assign src_vec[k] = 1'b0;
            end else begin : g_flag
                assign src_vec[k] = flags[k-1];
            end
        end
    endgenerate

    assign mux_out = src_vec[sel];
endmodule

// File: rtl/adc_trig_start.sv
`timescale 1ns/1ps
module adc_trig_start #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             mux_in,
    input  logic             auto_en,
    input  logic             conv_en,
    input  logic             conv_busy,
    input  logic             conv_done,
    output logic             start
);
    typedef struct packed {
        logic prev;
        logic start;
    } st_t;

    st_t  s_d, s_q;
    logic rise;
    logic free_run;
    logic req;

    always_comb begin
        rise       = mux_in & ~s_q.prev;
        free_run   = (sel == '0) & conv_done;
        req        = auto_en & (rise | free_run);
        s_d.prev   = mux_in;
        s_d.start  = req & conv_en & ~conv_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start = s_q.start;
endmodule

// File: rtl/adc_trig_pinmask.sv
`timescale 1ns/1ps
module adc_trig_pinmask #(
    parameter int PIN_W = 6
) (
    input  logic [PIN_W-1:0] pin_raw,
    input  logic [PIN_W-1:0] dis,
    output logic [PIN_W-1:0] pin_rd
);
    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_pin
            assign pin_rd[i] = pin_raw[i] & ~dis[i];
        end
    endgenerate
endmodule

// File: rtl/adc_trig_sel.sv
`timescale 1ns/1ps
module adc_trig_sel #(
    parameter int SEL_W  = 3,
    parameter int PIN_W  = 6,
    parameter int DATA_W = 8,
    localparam int NUM_FLAGS = (1 << SEL_W) - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_FLAGS-1:0] trig_flags,
    input  logic                 auto_en,
    input  logic                 conv_en,
    input  logic                 conv_busy,
    input  logic                 conv_done,
    input  logic [PIN_W-1:0]     pin_raw,
    output logic [PIN_W-1:0]     pin_rd,
    output logic                 start_conv
);
    logic [SEL_W-1:0] trig_sel;
    logic [PIN_W-1:0] pin_dis;
    logic             mux_val;

    adc_trig_regs #(.SEL_W(SEL_W), .PIN_W(PIN_W), .DATA_W(DATA_W)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .sel   (trig_sel),
        .dis   (pin_dis)
    );

    adc_trig_srcmux #(.SEL_W(SEL_W)) i_mux (
        .sel     (trig_sel),
        .flags   (trig_flags),
        .mux_out (mux_val)
    );

    adc_trig_start #(.SEL_W(SEL_W)) i_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (trig_sel),
        .mux_in    (mux_val),
        .auto_en   (auto_en),
        .conv_en   (conv_en),
        .conv_busy (conv_busy),
        .conv_done (conv_done),
        .start     (start_conv)
    );

    adc_trig_pinmask #(.PIN_W(PIN_W)) i_pins (
        .pin_raw (pin_raw),
        .dis     (pin_dis),
        .pin_rd  (pin_rd)
    );
endmodule

// File: rtl/adc_trig_sel_chk.sv
`timescale 1ns/1ps
module adc_trig_sel_chk #(
    parameter int SEL_W  = 3,
    parameter int PIN_W  = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [PIN_W-1:0]  pin_raw,
    input logic [PIN_W-1:0]  pin_rd,
    input logic              start_conv,
    input logic              auto_en,
    input logic              conv_en,
    input logic              conv_busy,
    input logic              conv_done,
    input logic [SEL_W-1:0]  sel
);
    AST_START_NEEDS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> $past(auto_en)); // R3

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> $past(conv_en)); // R7

    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> !$past(conv_busy)); // R8

    AST_NONE_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> ($past(sel) != '1)); // R9

    AST_FREE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_conv && ($past(sel) == '0)) |-> $past(conv_done)); // R5

    AST_DONE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && conv_en && !conv_busy && conv_done && (sel == '0)) |=> start_conv); // R6

    AST_TRIG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (reg_rdata[DATA_W-1:SEL_W] == '0)); // R10

    AST_PIN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rd & ~pin_raw) == '0); // R11
endmodule

bind adc_trig_sel adc_trig_sel_chk #(.SEL_W(SEL_W), .PIN_W(PIN_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .pin_raw    (pin_raw),
    .pin_rd     (pin_rd),
    .start_conv (start_conv),
    .auto_en    (auto_en),
    .conv_en    (conv_en),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .sel        (trig_sel)
);

// File: tb/test_adc_trig_sel.sv
`timescale 1ns/1ps
module test_adc_trig_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] trig_flags = '0;
    logic       auto_en = 1'b0;
    logic       conv_en = 1'b0;
    logic       conv_busy = 1'b0;
    logic       conv_done = 1'b0;
    logic [5:0] pin_raw = '0;
    logic [5:0] pin_rd;
    logic       start_conv;

    always #2.5 clk = ~clk;

    adc_trig_sel i_adc_trig_sel (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_flags(trig_flags),
        .auto_en(auto_en), .conv_en(conv_en), .conv_busy(conv_busy),
        .conv_done(conv_done), .pin_raw(pin_raw), .pin_rd(pin_rd),
        .start_conv(start_conv)
    );

    int    n_checks = 0;
    int    n_errs = 0;
    string req_tag = "R10";
    bit    finished = 1'b0;
    int    start_count = 0;

    // behavioural reference state
    int m_sel = 0;
    int m_dis = 0;
    bit m_prev = 1'b0;
    bit m_start = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_dis = 0; m_prev = 1'b0; m_start = 1'b0;
        end else begin
            bit cur;
            bit want;
            cur = (m_sel >= 1 && m_sel <= 6) ? trig_flags[m_sel-1] : 1'b0;
            want = auto_en && ((cur && !m_prev) || (m_sel == 0 && conv_done));
            m_start = want && conv_en && !conv_busy;
            m_prev = cur;
            if (reg_wr_en) begin
                if (reg_addr == 1'b0) m_sel = int'(reg_wdata) % 8;
                else                  m_dis = int'(reg_wdata) % 64;
            end
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
        end
    endtask

    task automatic tick();
        logic [7:0] exp_rd;
        @(posedge clk);
        @(negedge clk);
        exp_rd = reg_addr ? 8'(m_dis) : 8'(m_sel);
        if (start_conv) start_count++;
        chk("start_conv", {7'b0, start_conv}, {7'b0, m_start});
        chk("reg_rdata", reg_rdata, exp_rd);
        chk("pin_rd", {2'b0, pin_rd}, {2'b0, pin_raw & ~6'(m_dis)});
    endtask

    task automatic wr(logic a, logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL %s watchdog: actual=running expected=finished", req_tag);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        req_tag = "R10";
        chk("reset rdata0", reg_rdata, 8'h00);
        reg_addr = 1'b1;
        #0.1;
        chk("reset rdata1", reg_rdata, 8'h00);
        rst_n = 1'b1;
        tick();

        // R10 reserved bits of trigger register
        wr(1'b0, 8'hFF);
        chk("trig rsvd", reg_rdata, 8'h07);
        wr(1'b0, 8'h00);

        // R11 pin disable
        req_tag = "R11";
        pin_raw = 6'h3F;
        wr(1'b1, 8'hFF);
        chk("pdis rsvd", reg_rdata, 8'h3F);
        chk("pins all masked", {2'b0, pin_rd}, 8'h00);
        wr(1'b1, 8'h0C);
        pin_raw = 6'h2D; tick();
        chk("pins partial", {2'b0, pin_rd}, 8'h21);
        wr(1'b1, 8'h00);

        // R1 / R2 each source, held high gives one start
        auto_en = 1'b1; conv_en = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            req_tag = "R1";
            trig_flags = '0;
            wr(1'b0, 8'(c));
            tick();
            req_tag = "R2";
            start_count = 0;
            trig_flags[c-1] = 1'b1;
            repeat (5) tick();
            chk("one start per rise", 8'(start_count), 8'd1);
            trig_flags = '0;
            tick();
        end

        // R3 auto disabled, then re-enabled while flag high
        req_tag = "R3";
        wr(1'b0, 8'd2);
        auto_en = 1'b0; start_count = 0;
        for (int i = 0; i < 6; i++) begin
            trig_flags[1] = i[0];
            tick();
        end
        trig_flags[1] = 1'b1; tick();
        auto_en = 1'b1;
        repeat (3) tick();
        chk("no start while disabled", 8'(start_count), 8'd0);

        // R4 selection change low->high source
        req_tag = "R4";
        trig_flags = 6'b000100;
        wr(1'b0, 8'd1);
        tick();
        start_count = 0;
        wr(1'b0, 8'd3);
        tick();
        chk("start on select change", 8'(start_count), 8'd1);

        // R5 entering free-running with all flags high
        req_tag = "R5";
        trig_flags = 6'h3F;
        wr(1'b0, 8'd5);
        tick();
        start_count = 0;
        wr(1'b0, 8'd0);
        repeat (3) tick();
        chk("no start entering free run", 8'(start_count), 8'd0);

        // R6 free-running restart
        req_tag = "R6";
        conv_done = 1'b1; tick();
        conv_done = 1'b0;
        chk("restart after done", {7'b0, start_conv}, 8'd1);
        tick();

        // R7 converter disabled
        req_tag = "R7";
        conv_en = 1'b0; start_count = 0;
        conv_done = 1'b1; tick(); conv_done = 1'b0; tick();
        trig_flags = '0;
        wr(1'b0, 8'd4);
        trig_flags = 6'h3F; repeat (2) tick();
        chk("no start without enable", 8'(start_count), 8'd0);
        conv_en = 1'b1;

        // R8 busy drops request
        req_tag = "R8";
        trig_flags = '0; tick();
        conv_busy = 1'b1; trig_flags = 6'h08; tick();
        conv_busy = 1'b0; start_count = 0;
        repeat (3) tick();
        chk("busy request dropped", 8'(start_count), 8'd0);

        // R9 tied-off code
        req_tag = "R9";
        wr(1'b0, 8'd7);
        start_count = 0;
        for (int i = 0; i < 8; i++) begin
            trig_flags = i[0] ? 6'h3F : 6'h00;
            conv_done = i[1];
            tick();
        end
        conv_done = 1'b0;
        chk("code 7 quiet", 8'(start_count), 8'd0);

        // mixed traffic against the model
        req_tag = "R1";
        for (int i = 0; i < 600; i++) begin
            trig_flags = 6'($urandom);
            auto_en   = ($urandom % 5) != 0;
            conv_en   = ($urandom % 5) != 0;
            conv_busy = ($urandom % 4) == 0;
            conv_done = ($urandom % 4) == 0;
            pin_raw   = 6'($urandom);
            reg_addr  = 1'($urandom);
            if (($urandom % 5) == 0) wr(1'($urandom), 8'($urandom));
            else tick();
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule